// File: doc/BRIEF.md
# Set-Associative Page Translation Cache

This block keeps recently used page translations so that an access that hits does not need the two-level table walk. A requester presents a 20-bit linear page number (linear address bits 31:12), a write flag and a user-level flag. In the same cycle the block answers with either a hit, carrying the 20-bit physical frame number and the stored user and writable attributes, or a miss. The cache has 32 entries arranged as 8 sets of 4 ways. With 4 KB pages this covers 128 KB.

After a miss, the external walker returns the translation through the fill port. The fill is written on the clock edge of the cycle in which it is offered. A write that hits an entry whose stored dirty flag is clear is reported as a miss with a separate dirty-miss flag. This lets the walker mark the page dirty in memory and refill the entry. A reload of the page-directory base is signalled by a flush input, which empties the whole cache. A single page can be removed with the invalidate port.

Top module: `pageXlatCache`

## Requirements
- R1: After reset every entry is invalid, so every lookup gives hit=0 and miss=1.
- R2: A fill is visible to a lookup on the next cycle. A read lookup of a cached page gives hit=1 and miss=0 in the same cycle, with hitFrame, hitUser and hitWritable equal to the filled values. With lookupValid=1, miss is always the inverse of hit.
- R3: flushAll=1 makes every entry invalid from the next cycle on.
- R4: A write lookup (lookupWrite=1) that matches an entry whose stored dirty flag is 0 gives hit=0, miss=1 and dirtyMiss=1. A write lookup that matches an entry whose dirty flag is 1 is an ordinary hit.
- R5: accessDenied=1 only together with hit=1, when lookupUser=1 and either the entry is a supervisor page (user attribute 0) or the access is a write to a page whose writable attribute is 0. A lookup with lookupUser=0 is never denied.
- R6: The set index is page bits 2:0 (linear address 14:12) and the tag is page bits 19:3. A fill into a set that has invalid ways uses the lowest-numbered invalid way. Entries in other sets are left untouched.
- R7: In a full set the victim is picked by a 3-bit tree. Root bit 0 selects ways 0-1 and root bit 1 selects ways 2-3. Inside the chosen pair, a leaf bit of 0 selects the lower way and a leaf bit of 1 selects the upper way. Every hit and every fill points the tree away from the way it used. The tree starts at zero after reset.
- R8: A fill for a page that is already cached overwrites that entry in place, so no page is ever held twice.
- R9: An invalidate removes only the entry for the given page. Invalidating a page that is not cached changes nothing.
- R10: A fill offered in the same cycle as flushAll or as an invalidate is dropped.
- R11: All 32 entries (4 in each of the 8 sets) can be valid at once, and each one hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lookupValid | input | 1 | A lookup is presented this cycle |
| lookupPage | input | 20 | Linear page number to translate |
| lookupWrite | input | 1 | The access is a write |
| lookupUser | input | 1 | The access comes from user level |
| hit | output | 1 | Translation found and usable |
| miss | output | 1 | Lookup needs the walker |
| dirtyMiss | output | 1 | Miss caused by a write to a clean page |
| accessDenied | output | 1 | Hit violates the page protection |
| hitFrame | output | 20 | Physical frame number on a hit |
| hitUser | output | 1 | User attribute of the hit entry |
| hitWritable | output | 1 | Writable attribute of the hit entry |
| fillValid | input | 1 | Write a translation this cycle |
| fillPage | input | 20 | Linear page number of the fill |
| fillFrame | input | 20 | Physical frame number of the fill |
| fillUser | input | 1 | User attribute of the fill |
| fillWritable | input | 1 | Writable attribute of the fill |
| fillDirty | input | 1 | Dirty flag of the fill |
| flushAll | input | 1 | Invalidate every entry |
| invValid | input | 1 | Invalidate one page this cycle |
| invPage | input | 20 | Page to invalidate |

## Verification
A fill can arrive in the same cycle as a flush, and also in the same cycle as a single-page invalidate. In both cases the fill must lose. The bench drives both pairs in a single cycle: a flush together with a fill, and an invalidate of a cached page together with a fill of a different page. It then looks up the filled page, and a miss is the pass condition. Lookups of the other cached pages confirm that the flush emptied the cache and that the invalidate still removed its target.

// File: rtl/pxcPkg.sv
package pxcPkg;
  parameter int unsigned PAGE_W  = 20;
  parameter int unsigned FRAME_W = 20;
  parameter int unsigned SETS    = 8;
  // The replacement tree below is written for four ways.
  parameter int unsigned WAYS    = 4;

  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned TAG_W = PAGE_W - IDX_W;
  localparam int unsigned LRU_W = WAYS - 1;

  typedef struct packed {
    logic               user;
    logic               writable;
    logic               dirty;
    logic [FRAME_W-1:0] frame;
  } entryAttrT;

  typedef struct packed {
    logic             flushAll;
    logic             fillWe;
    logic [IDX_W-1:0] fillSet;
    logic [WAYS-1:0]  fillWayOh;
    logic             invWe;
    logic [IDX_W-1:0] invSet;
    logic [WAYS-1:0]  invWayOh;
  } strobeT;
endpackage

// File: rtl/pxcStore.sv
module pxcStore
  import pxcPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [PAGE_W-1:0] lookupPage,
  input  logic [PAGE_W-1:0] fillPage,
  input  logic [PAGE_W-1:0] invPage,
  input  entryAttrT         fillAttr,
  output logic [WAYS-1:0]   lookupMatch,
  output logic [WAYS-1:0]   fillMatch,
  output logic [WAYS-1:0]   invMatch,
  output logic [WAYS-1:0]   fillSetValid,
  output entryAttrT         lookupAttr
);
  logic [WAYS-1:0]  validQ [SETS];
  logic [TAG_W-1:0] tagQ   [SETS][WAYS];
  entryAttrT        attrQ  [SETS][WAYS];

  logic [IDX_W-1:0] lookupSet, fillSet, invSet;
  logic [TAG_W-1:0] lookupTag, fillTag, invTag;

  assign lookupSet = lookupPage[IDX_W-1:0];
  assign lookupTag = lookupPage[PAGE_W-1:IDX_W];
  assign fillSet   = fillPage[IDX_W-1:0];
  assign fillTag   = fillPage[PAGE_W-1:IDX_W];
  assign invSet    = invPage[IDX_W-1:0];
  assign invTag    = invPage[PAGE_W-1:IDX_W];

  // Parallel tag compare, one comparator per way and per port
  for (genvar w = 0; w < WAYS; w++) begin : gWay
    assign lookupMatch[w]  = validQ[lookupSet][w] && (tagQ[lookupSet][w] == lookupTag);
    assign fillMatch[w]    = validQ[fillSet][w]   && (tagQ[fillSet][w]   == fillTag);
    assign invMatch[w]     = validQ[invSet][w]    && (tagQ[invSet][w]    == invTag);
    assign fillSetValid[w] = validQ[fillSet][w];
  end

  // AND-OR result mux: at most one way matches
  always_comb begin
    lookupAttr = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lookupMatch[w]) lookupAttr = lookupAttr | attrQ[lookupSet][w];
    end
  end

  // Valid bits: reset and flush clear all (R1, R3)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) validQ[s] <= '0;
    end else if (strb.flushAll) begin
      for (int s = 0; s < SETS; s++) validQ[s] <= '0;
    end else begin
      if (strb.invWe)  validQ[strb.invSet]  <= validQ[strb.invSet] & ~strb.invWayOh;
      if (strb.fillWe) validQ[strb.fillSet] <= validQ[strb.fillSet] | strb.fillWayOh;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.fillWe) begin
      for (int w = 0; w < WAYS; w++) begin
        if (strb.fillWayOh[w]) begin
          tagQ[strb.fillSet][w]  <= fillTag;
          attrQ[strb.fillSet][w] <= fillAttr;
        end
      end
    end
  end

  logic anyValid;
  always_comb begin
    anyValid = 1'b0;
    for (int s = 0; s < SETS; s++) anyValid = anyValid | (|validQ[s]);
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    strb.flushAll |=> !anyValid); // R3
  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strb.fillWe |=> ((validQ[$past(strb.fillSet)] & $past(strb.fillWayOh)) != '0)); // R2
  AST_INV_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.invWe |=> ((validQ[$past(strb.invSet)] & $past(strb.invWayOh)) == '0)); // R9
  AST_NO_DUPLICATE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lookupMatch)); // R8
endmodule

// File: rtl/pxcCtrl.sv
module pxcCtrl
  import pxcPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic [IDX_W-1:0] lookupSet,
  input  logic             lookupWrite,
  input  logic             lookupUser,
  input  logic             fillValid,
  input  logic [IDX_W-1:0] fillSet,
  input  logic             flushAll,
  input  logic             invValid,
  input  logic [IDX_W-1:0] invSet,
  input  logic [WAYS-1:0]  lookupMatch,
  input  logic [WAYS-1:0]  fillMatch,
  input  logic [WAYS-1:0]  invMatch,
  input  logic [WAYS-1:0]  fillSetValid,
  input  logic             entryDirty,
  input  logic             entryUser,
  input  logic             entryWritable,
  output strobeT           strb,
  output logic             hit,
  output logic             miss,
  output logic             dirtyMiss,
  output logic             accessDenied
);
  logic [LRU_W-1:0] lruQ [SETS];
  logic [WAYS-1:0]  fillWayOh;
  logic             lookupAny, dirtyBlock;

  function automatic logic [WAYS-1:0] treeVictim(input logic [LRU_W-1:0] t);
    if (!t[0]) return t[1] ? 4'b0010 : 4'b0001;
    else       return t[2] ? 4'b1000 : 4'b0100;
  endfunction

  function automatic logic [LRU_W-1:0] treeTouch(input logic [LRU_W-1:0] t,
                                                 input logic [WAYS-1:0] oh);
    logic [LRU_W-1:0] n;
    n = t;
    if (oh[0]) begin n[0] = 1'b1; n[1] = 1'b1; end
    if (oh[1]) begin n[0] = 1'b1; n[1] = 1'b0; end
    if (oh[2]) begin n[0] = 1'b0; n[2] = 1'b1; end
    if (oh[3]) begin n[0] = 1'b0; n[2] = 1'b0; end
    return n;
  endfunction

  // Lookup result
  assign lookupAny    = |lookupMatch;
  assign dirtyBlock   = lookupValid && lookupAny && lookupWrite && !entryDirty;
  assign hit          = lookupValid && lookupAny && !dirtyBlock;
  assign miss         = lookupValid && !hit;
  assign dirtyMiss    = dirtyBlock;
  assign accessDenied = hit && lookupUser && (!entryUser || (lookupWrite && !entryWritable));

  // Way choice: existing entry, then lowest invalid way, then tree victim
  always_comb begin
    logic found;
    found     = 1'b0;
    fillWayOh = '0;
    if (|fillMatch) begin
      fillWayOh = fillMatch;
    end else if (!(&fillSetValid)) begin
      for (int w = 0; w < WAYS; w++) begin
        if (!found && !fillSetValid[w]) begin
          fillWayOh[w] = 1'b1;
          found        = 1'b1;
        end
      end
    end else begin
      fillWayOh = treeVictim(lruQ[fillSet]);
    end
  end

  // Strobes to the store; flush and invalidate win over a fill
  always_comb begin
    strb.flushAll  = flushAll;
    strb.invWe     = invValid && (|invMatch) && !flushAll;
    strb.invSet    = invSet;
    strb.invWayOh  = invMatch;
    strb.fillWe    = fillValid && !flushAll && !invValid;
    strb.fillSet   = fillSet;
    strb.fillWayOh = fillWayOh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) lruQ[s] <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) begin
        if (strb.fillWe && (fillSet == IDX_W'(s)))
          lruQ[s] <= treeTouch(lruQ[s], fillWayOh);
        else if (hit && (lookupSet == IDX_W'(s)))
          lruQ[s] <= treeTouch(lruQ[s], lookupMatch);
      end
    end
  end

  AST_FILL_INVALID_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fillWe && !(|fillMatch) && !(&fillSetValid)) |-> ((fillWayOh & fillSetValid) == '0)); // R6
  AST_FILL_ONE_WAY: assert property (@(posedge clk) disable iff (!rstN)
    strb.fillWe |-> ($countones(fillWayOh) == 1)); // R7
  AST_DENIED_NEEDS_USER: assert property (@(posedge clk) disable iff (!rstN)
    accessDenied |-> (lookupUser && hit)); // R5
endmodule

// File: rtl/pageXlatCache.sv
module pageXlatCache
  import pxcPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               lookupValid,
  input  logic [PAGE_W-1:0]  lookupPage,
  input  logic               lookupWrite,
  input  logic               lookupUser,
  output logic               hit,
  output logic               miss,
  output logic               dirtyMiss,
  output logic               accessDenied,
  output logic [FRAME_W-1:0] hitFrame,
  output logic               hitUser,
  output logic               hitWritable,
  input  logic               fillValid,
  input  logic [PAGE_W-1:0]  fillPage,
  input  logic [FRAME_W-1:0] fillFrame,
  input  logic               fillUser,
  input  logic               fillWritable,
  input  logic               fillDirty,
  input  logic               flushAll,
  input  logic               invValid,
  input  logic [PAGE_W-1:0]  invPage
);
  strobeT          strb;
  entryAttrT       fillAttr, lookupAttr;
  logic [WAYS-1:0] lookupMatch, fillMatch, invMatch, fillSetValid;

  assign fillAttr = '{user: fillUser, writable: fillWritable, dirty: fillDirty, frame: fillFrame};

  pxcStore i_store (
    .clk, .rstN, .strb,
    .lookupPage, .fillPage, .invPage, .fillAttr,
    .lookupMatch, .fillMatch, .invMatch, .fillSetValid, .lookupAttr
  );

  pxcCtrl i_ctrl (
    .clk, .rstN,
    .lookupValid, .lookupSet(lookupPage[IDX_W-1:0]), .lookupWrite, .lookupUser,
    .fillValid, .fillSet(fillPage[IDX_W-1:0]),
    .flushAll, .invValid, .invSet(invPage[IDX_W-1:0]),
    .lookupMatch, .fillMatch, .invMatch, .fillSetValid,
    .entryDirty(lookupAttr.dirty), .entryUser(lookupAttr.user),
    .entryWritable(lookupAttr.writable),
    .strb, .hit, .miss, .dirtyMiss, .accessDenied
  );

  assign hitFrame    = lookupAttr.frame;
  assign hitUser     = lookupAttr.user;
  assign hitWritable = lookupAttr.writable;
endmodule

// File: tb/test_pageXlatCache.sv
module test_pageXlatCache;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic        lookupValid, lookupWrite, lookupUser;
  logic [19:0] lookupPage;
  logic        hit, miss, dirtyMiss, accessDenied, hitUser, hitWritable;
  logic [19:0] hitFrame;
  logic        fillValid, fillUser, fillWritable, fillDirty;
  logic [19:0] fillPage, fillFrame;
  logic        flushAll, invValid;
  logic [19:0] invPage;

  pageXlatCache i_pageXlatCache (
    .clk, .rstN, .lookupValid, .lookupPage, .lookupWrite, .lookupUser,
    .hit, .miss, .dirtyMiss, .accessDenied, .hitFrame, .hitUser, .hitWritable,
    .fillValid, .fillPage, .fillFrame, .fillUser, .fillWritable, .fillDirty,
    .flushAll, .invValid, .invPage
  );

  typedef struct {
    logic        eHit;
    logic        eDirtyMiss;
    logic        eDenied;
    logic [19:0] eFrame;
    logic        eUser;
    logic        eWr;
    logic [19:0] page;
    string       req;
  } expT;

  expT sbQ[$];
  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  localparam logic [19:0] PG_A = 20'h12345;
  localparam logic [19:0] PG_B = 20'h00011;
  localparam logic [19:0] PG_C = 20'h00023;
  localparam logic [19:0] PG_D = 20'h00034;
  localparam logic [19:0] PG_E = 20'h00046;

  function automatic logic [19:0] setTwo(input int t);
    return 20'((t << 3) | 2);
  endfunction

  task automatic clearIn();
    lookupValid = 0; lookupPage = '0; lookupWrite = 0; lookupUser = 0;
    fillValid = 0; fillPage = '0; fillFrame = '0; fillUser = 0; fillWritable = 0; fillDirty = 0;
    flushAll = 0; invValid = 0; invPage = '0;
  endtask

  task automatic doFill(input logic [19:0] pg, input logic [19:0] fr,
                        input logic u, input logic w, input logic d);
    @(negedge clk); #1;
    clearIn();
    fillValid = 1; fillPage = pg; fillFrame = fr; fillUser = u; fillWritable = w; fillDirty = d;
  endtask

  task automatic doLook(input logic [19:0] pg, input logic wr, input logic usr,
                        input logic eh, input logic edm, input logic eden,
                        input logic [19:0] ef, input logic eu, input logic ew, input string req);
    expT e;
    @(negedge clk); #1;
    clearIn();
    lookupValid = 1; lookupPage = pg; lookupWrite = wr; lookupUser = usr;
    e.eHit = eh; e.eDirtyMiss = edm; e.eDenied = eden; e.eFrame = ef;
    e.eUser = eu; e.eWr = ew; e.page = pg; e.req = req;
    sbQ.push_back(e);
  endtask

  task automatic expectHit(input logic [19:0] pg, input logic [19:0] ef,
                           input logic eu, input logic ew, input string req);
    doLook(pg, 0, 0, 1, 0, 0, ef, eu, ew, req);
  endtask

  task automatic expectMiss(input logic [19:0] pg, input string req);
    doLook(pg, 0, 0, 0, 0, 0, '0, 0, 0, req);
  endtask

  task automatic doInv(input logic [19:0] pg);
    @(negedge clk); #1;
    clearIn();
    invValid = 1; invPage = pg;
  endtask

  task automatic doIdle();
    @(negedge clk); #1;
    clearIn();
  endtask

  // Monitor: compares the presented lookup before the next rising edge
  initial begin
    forever begin
      @(negedge clk); #3;
      if (sbQ.size() > 0) begin
        expT e;
        logic ok;
        e = sbQ.pop_front();
        checks++;
        ok = (hit == e.eHit) && (miss == !e.eHit) && (dirtyMiss == e.eDirtyMiss) &&
             (accessDenied == e.eDenied) &&
             (!e.eHit || (hitFrame == e.eFrame && hitUser == e.eUser && hitWritable == e.eWr));
        if (!ok) begin
          failures++;
          $display("FAIL %s page=%h actual hit=%b miss=%b dm=%b den=%b frame=%h u=%b w=%b expected hit=%b miss=%b dm=%b den=%b frame=%h u=%b w=%b",
                   e.req, e.page, hit, miss, dirtyMiss, accessDenied, hitFrame, hitUser, hitWritable,
                   e.eHit, !e.eHit, e.eDirtyMiss, e.eDenied, e.eFrame, e.eUser, e.eWr);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clearIn();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: empty after reset
    expectMiss(20'h00005, "R1");
    expectMiss(PG_A, "R1");

    // R2: fill then hit with attributes
    doFill(PG_A, 20'hABCDE, 1, 1, 1);
    expectHit(PG_A, 20'hABCDE, 1, 1, "R2");

    // R4: write to dirty page hits; write to clean page gives dirty miss
    doLook(PG_A, 1, 0, 1, 0, 0, 20'hABCDE, 1, 1, "R4");
    doFill(PG_B, 20'h0B0B0, 1, 1, 0);
    doLook(PG_B, 1, 0, 0, 1, 0, '0, 0, 0, "R4");
    expectHit(PG_B, 20'h0B0B0, 1, 1, "R4");

    // R5: protection flags
    doFill(PG_C, 20'h0C0C0, 0, 1, 1);
    doLook(PG_C, 0, 1, 1, 0, 1, 20'h0C0C0, 0, 1, "R5");
    doLook(PG_C, 0, 0, 1, 0, 0, 20'h0C0C0, 0, 1, "R5");
    doFill(PG_D, 20'h0D0D0, 1, 0, 1);
    doLook(PG_D, 1, 1, 1, 0, 1, 20'h0D0D0, 1, 0, "R5");
    doLook(PG_D, 1, 0, 1, 0, 0, 20'h0D0D0, 1, 0, "R5");
    doLook(PG_D, 0, 1, 1, 0, 0, 20'h0D0D0, 1, 0, "R5");

    // R6: four fills into set 2 take the free ways
    for (int t = 1; t <= 4; t++) doFill(setTwo(t), 20'h20000 + 20'(t), 1, 1, 1);
    for (int t = 1; t <= 4; t++) expectHit(setTwo(t), 20'h20000 + 20'(t), 1, 1, "R6");

    // R7: tree victim. Fifth fill evicts way 0; after a hit on way 1 the next fill evicts way 2
    doFill(setTwo(5), 20'h20005, 1, 1, 1);
    expectMiss(setTwo(1), "R7");
    expectHit(setTwo(2), 20'h20002, 1, 1, "R7");
    doFill(setTwo(6), 20'h20006, 1, 1, 1);
    expectMiss(setTwo(3), "R7");
    expectHit(setTwo(4), 20'h20004, 1, 1, "R7");
    expectHit(setTwo(5), 20'h20005, 1, 1, "R7");
    expectHit(setTwo(6), 20'h20006, 1, 1, "R7");
    expectHit(setTwo(2), 20'h20002, 1, 1, "R7");
    expectHit(PG_A, 20'hABCDE, 1, 1, "R6");

    // R8: refill of a cached page replaces it
    doFill(PG_A, 20'h55555, 1, 1, 1);
    expectHit(PG_A, 20'h55555, 1, 1, "R8");

    // R9: single-page invalidate
    doInv(PG_B);
    expectMiss(PG_B, "R9");
    expectHit(PG_A, 20'h55555, 1, 1, "R9");
    doInv(20'h77777);
    expectHit(PG_A, 20'h55555, 1, 1, "R9");
    expectHit(PG_C, 20'h0C0C0, 0, 1, "R9");

    // R10: invalidate and fill in one cycle
    @(negedge clk); #1;
    clearIn();
    invValid = 1; invPage = PG_C;
    fillValid = 1; fillPage = PG_E; fillFrame = 20'h0E0E0; fillUser = 1; fillWritable = 1; fillDirty = 1;
    expectMiss(PG_E, "R10");
    expectMiss(PG_C, "R9");

    // R10 and R3: flush and fill in one cycle
    @(negedge clk); #1;
    clearIn();
    flushAll = 1;
    fillValid = 1; fillPage = PG_E; fillFrame = 20'h0E0E0; fillUser = 1; fillWritable = 1; fillDirty = 1;
    expectMiss(PG_E, "R10");
    expectMiss(PG_A, "R3");
    expectMiss(PG_D, "R3");
    expectMiss(setTwo(6), "R3");

    // R11: full capacity
    for (int i = 0; i < 32; i++) doFill(20'(i), 20'h00100 + 20'(i), 1, 1, 1);
    for (int i = 0; i < 32; i++) expectHit(20'(i), 20'h00100 + 20'(i), 1, 1, "R11");

    doIdle();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule